// File: doc/BRIEF.md
# SDRAM Bank State and Timing Tracker

This block sits beside a memory controller and watches the decoded command stream sent to a multi-bank SDRAM. For each bank it keeps a state (closed, open with a row, open with a pending automatic close, or closing) along with a single per-bank timer. It judges every command against that state in the same cycle, raises an illegal flag for any command that breaks a protocol rule, and discards such a command without touching any state.

It also follows the clock-enable input. While clock enable is low, the tracker freezes and ignores commands. If all banks are closed and no mode-register wait is running, it reports power-down. A refresh window counter reports whether the current window still owes refresh commands.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Command codes are 0 no-op, 1 open (activate), 2 read, 3 write, 4 close one bank, 5 close all banks, 6 refresh, 7 mode load. A no-op is never flagged. After reset every bank reads state 0 (closed), power-down is low and refresh-due is high.
- R2: An open command is legal only on a bank in state 0. Once accepted, the bank shows state 1 and its row field holds the given row from the next cycle on.
- R3: A read or write is legal only on a bank in state 1 when at least T_RCD cycles have passed since that bank's open command, so an open at cycle t allows a read at t+T_RCD.
- R4: Closing one bank is legal only in state 1 and at least T_RAS cycles after its open. The bank then shows state 2 and returns to state 0 T_RP cycles after the close command.
- R5: A legal read or write with `auto_close` set puts the bank in state 3 for BL cycles. In that state every command to the bank is illegal. The close then begins as if issued BL cycles after the read, so the bank shows state 2 and reaches state 0 BL+T_RP cycles after the read.
- R6: Close-all is legal unless some bank is in state 3, or some bank is in state 1 with fewer than T_RAS cycles since its open. When accepted, every bank in state 1 enters state 2.
- R7: Refresh and mode load are legal only when every bank is in state 0. After an accepted mode load, every non-no-op command is illegal for T_MRD-1 cycles.
- R8: An illegal command is flagged in the cycle it is presented and changes no bank state, timer or row.
- R9: `refresh_due` is high until REF_NEED legal refreshes have been accepted within the current window of REF_WIN cycles counted from reset. The count restarts at each window boundary.
- R10: While `cke` is low, commands are ignored and not flagged, and all bank states and timers hold. In the cycle after a low `cke` with all banks closed and no mode-load wait, `pwr_down` is high. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable seen by the device |
| cmd | input | 3 | Decoded command code (R1) |
| auto_close | input | 1 | Read/write closes the bank when its burst ends |
| bank | input | $clog2(NBANK) | Target bank |
| row | input | ROW_W | Row for an open command |
| bank_state | output | 2*NBANK | 2-bit state per bank, bank 0 in the low bits |
| open_row | output | NBANK*ROW_W | Open row per bank, bank 0 in the low bits |
| cmd_illegal | output | 1 | Present command breaks a rule and is discarded |
| refresh_due | output | 1 | Current window still owes refreshes |
| pwr_down | output | 1 | Device is in power-down |

## Verification
The assertions check on every cycle that a no-op is never flagged, that an accepted open leaves the bank in state 1 with the given row, and that a rejected command leaves an open bank open. They also check that a closing or auto-close bank moves only forward, that a low clock enable freezes every state, timer and row, and that power-down never coexists with an open bank. The exact cycles at which reads, closes and close-all become legal, the length of the auto-close and closing phases, the timer freeze across a clock-enable gap, and the refresh window accounting can only be shown by the bench. It sweeps the command spacing across the timing limits on every bank and compares against limits computed from the parameters.

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NBANK    = 4,
  parameter int ROW_W    = 13,
  parameter int T_RCD    = 3,
  parameter int T_RAS    = 6,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int BL       = 4,
  parameter int REF_WIN  = 1024,
  parameter int REF_NEED = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic [2:0]                 cmd,
  input  logic                       auto_close,
  input  logic [$clog2(NBANK)-1:0]   bank,
  input  logic [ROW_W-1:0]           row,
  output logic [2*NBANK-1:0]         bank_state,
  output logic [NBANK*ROW_W-1:0]     open_row,
  output logic                       cmd_illegal,
  output logic                       refresh_due,
  output logic                       pwr_down
);
  localparam int BW      = $clog2(NBANK);
  localparam int AGE_MAX = (T_RAS > T_RCD) ? T_RAS : T_RCD;
  localparam int TM0     = (AGE_MAX > BL) ? AGE_MAX : BL;
  localparam int TMAX    = (TM0 > T_RP) ? TM0 : T_RP;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int MW      = $clog2(T_MRD + 1);
  localparam int WW      = $clog2(REF_WIN);
  localparam int RW      = $clog2(REF_NEED + 1);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_PREA = 3'd5, C_REF = 3'd6, C_MRS = 3'd7;
  localparam logic [1:0] S_IDLE = 2'd0, S_ACT = 2'd1, S_PRE = 2'd2, S_AP = 2'd3;

  logic [1:0]       st    [NBANK];
  logic [TW-1:0]    tmr   [NBANK];
  logic [ROW_W-1:0] row_q [NBANK];
  logic [MW-1:0]    mrd;
  logic [WW-1:0]    win;
  logic [RW-1:0]    refs;
  logic             pd_q;
  logic             all_idle, prea_ok, legal, go;
  logic [1:0]       bst;
  logic [TW-1:0]    btm;

  assign bst = st[bank];
  assign btm = tmr[bank];

  always_comb begin
    all_idle = 1'b1;
    prea_ok  = 1'b1;
    for (int i = 0; i < NBANK; i++) begin
      if (st[i] != S_IDLE) all_idle = 1'b0;
      if (st[i] == S_AP || (st[i] == S_ACT && tmr[i] < TW'(T_RAS))) prea_ok = 1'b0;
    end
  end

  always_comb begin
    case (cmd)
      C_NOP:        legal = 1'b1;
      C_ACT:        legal = (bst == S_IDLE);
      C_RD, C_WR:   legal = (bst == S_ACT) && (btm >= TW'(T_RCD));
      C_PRE:        legal = (bst == S_ACT) && (btm >= TW'(T_RAS));
      C_PREA:       legal = prea_ok;
      default:      legal = all_idle;
    endcase
    if (cmd != C_NOP && mrd != '0) legal = 1'b0;
  end

  assign cmd_illegal = cke && !legal;
  assign go          = cke && legal && (cmd != C_NOP);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit;
    assign hit = go && (bank == BW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[i]    <= S_IDLE;
        tmr[i]   <= '0;
        row_q[i] <= '0;
      end else if (cke) begin
        case (st[i])
          S_IDLE: if (hit && cmd == C_ACT) begin
            st[i]    <= S_ACT;
            tmr[i]   <= TW'(1);
            row_q[i] <= row;
          end
          S_ACT: begin
            if ((hit && cmd == C_PRE) || (go && cmd == C_PREA)) begin
              st[i]  <= (T_RP <= 1) ? S_IDLE : S_PRE;
              tmr[i] <= (T_RP <= 1) ? '0 : TW'(T_RP - 1);
            end else if (hit && (cmd == C_RD || cmd == C_WR) && auto_close) begin
              st[i]  <= S_AP;
              tmr[i] <= TW'(BL);
            end else if (tmr[i] < TW'(AGE_MAX)) begin
              tmr[i] <= tmr[i] + 1'b1;
            end
          end
          S_PRE: begin
            if (tmr[i] <= TW'(1)) begin
              st[i]  <= S_IDLE;
              tmr[i] <= '0;
            end else begin
              tmr[i] <= tmr[i] - 1'b1;
            end
          end
          default: begin
            if (tmr[i] <= TW'(1)) begin
              st[i]  <= (T_RP <= 1) ? S_IDLE : S_PRE;
              tmr[i] <= (T_RP <= 1) ? '0 : TW'(T_RP - 1);
            end else begin
              tmr[i] <= tmr[i] - 1'b1;
            end
          end
        endcase
      end
    end

    assign bank_state[2*i +: 2]      = st[i];
    assign open_row[ROW_W*i +: ROW_W] = row_q[i];

    assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cmd == C_ACT && bank == BW'(i) && !cmd_illegal)
      |=> (st[i] == S_ACT && row_q[i] == $past(row)));

    assert_reject_keeps_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_illegal && st[i] == S_ACT) |=> (st[i] == S_ACT));

    assert_closing_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && st[i] == S_PRE) |=> (st[i] == S_PRE || st[i] == S_IDLE));

    assert_autoclose_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && st[i] == S_AP) |=> (st[i] != S_ACT));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke) |=> (st[i] == $past(st[i]) && tmr[i] == $past(tmr[i])
                  && row_q[i] == $past(row_q[i])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrd  <= '0;
      win  <= '0;
      refs <= '0;
      pd_q <= 1'b0;
    end else begin
      win  <= (win == WW'(REF_WIN - 1)) ? '0 : win + 1'b1;
      pd_q <= !cke && all_idle && (mrd == '0);
      if (win == WW'(REF_WIN - 1))
        refs <= '0;
      else if (go && cmd == C_REF && refs < RW'(REF_NEED))
        refs <= refs + 1'b1;
      if (cke) begin
        if (go && cmd == C_MRS) mrd <= MW'(T_MRD - 1);
        else if (mrd != '0)     mrd <= mrd - 1'b1;
      end
    end
  end

  assign refresh_due = (refs < RW'(REF_NEED));
  assign pwr_down    = pd_q;

  assert_noop_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_NOP) |-> !cmd_illegal);

  assert_sleep_unflagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke) |-> !cmd_illegal);

  assert_pd_all_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (bank_state == '0));

  if (T_MRD >= 2) begin : g_mrd_chk
    assert_mode_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cmd == C_MRS && !cmd_illegal)
      |=> (!(cke && cmd != C_NOP) || cmd_illegal));
  end
endmodule

// File: tb/sdram_bank_tracker_bench.sv
module sdram_bank_tracker_bench;
  localparam int NB = 4, RWD = 13, TRCD = 3, TRAS = 5, TRP = 3, TMRD = 2, BLEN = 4;
  localparam int WIN = 40, NEED = 3;
  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PREA = 5, REF = 6, MRS = 7;

  logic clk = 0, rst_n = 0, cke = 1, auto_close = 0;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = 0;
  logic [RWD-1:0] row = 0;
  logic [2*NB-1:0] bank_state;
  logic [NB*RWD-1:0] open_row;
  logic cmd_illegal, refresh_due, pwr_down;
  int vectors = 0, miscompares = 0, ncyc = 0;
  bit done = 0, bad;

  always #4 clk = ~clk;
  always @(posedge clk) ncyc <= rst_n ? ncyc + 1 : 0;

  sdram_bank_tracker #(.NBANK(NB), .ROW_W(RWD), .T_RCD(TRCD), .T_RAS(TRAS), .T_RP(TRP),
    .T_MRD(TMRD), .BL(BLEN), .REF_WIN(WIN), .REF_NEED(NEED)) u_sdram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .auto_close(auto_close), .bank(bank),
    .row(row), .bank_state(bank_state), .open_row(open_row), .cmd_illegal(cmd_illegal),
    .refresh_due(refresh_due), .pwr_down(pwr_down));

  function automatic int st_of(int b); return int'(bank_state[2*b +: 2]); endfunction
  function automatic int row_of(int b); return int'(open_row[RWD*b +: RWD]); endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, ncyc);
    end
  endtask

  task automatic cyc(logic [2:0] c, int b = 0, int r = 0, bit ap = 0, bit ck = 1);
    @(negedge clk);
    cmd = c; bank = 2'(b); row = RWD'(r); auto_close = ap; cke = ck;
    #1;
    bad = cmd_illegal;
  endtask

  task automatic close_bank(int b);
    repeat (TRAS) cyc(NOP);
    cyc(PRE, b);
    chk("R4 close after tRAS", int'(bad), 0);
    repeat (TRP) cyc(NOP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int b = 0; b < NB; b++) chk("R1 reset state", st_of(b), 0);
    rst_n = 1;
    cyc(NOP);
    chk("R1 noop legal", int'(bad), 0);
    chk("R1 power-down low", int'(pwr_down), 0);
    chk("R1 refresh due after reset", int'(refresh_due), 1);

    // R3 sweep: read/write spacing after open, every bank
    for (int b = 0; b < NB; b++) begin
      for (int d = 1; d <= TRCD + 1; d++) begin
        int r = b * 16 + d + 1;
        cyc(ACT, b, r);
        chk("R2 open idle bank", int'(bad), 0);
        repeat (d - 1) cyc(NOP);
        cyc((d % 2) ? RD : WR, b);
        chk("R3 read/write vs tRCD", int'(bad), int'(d < TRCD));
        chk("R2 state open", st_of(b), 1);
        chk("R2 open row", row_of(b), r);
        close_bank(b);
      end
    end

    // R4 sweep: close spacing and closing phase
    for (int d = 1; d <= TRAS + 1; d++) begin
      int b = d % NB;
      cyc(ACT, b, d);
      repeat (d - 1) cyc(NOP);
      cyc(PRE, b);
      chk("R4 close vs tRAS", int'(bad), int'(d < TRAS));
      if (d < TRAS) begin
        cyc(NOP);
        chk("R8 rejected close keeps open", st_of(b), 1);
        close_bank(b);
      end else begin
        for (int k = 1; k <= TRP; k++) begin
          cyc(NOP);
          chk("R4 closing phase", st_of(b), (k < TRP) ? 2 : 0);
        end
      end
    end

    // R2/R8: reopen rejected, row untouched; open during closing rejected
    cyc(ACT, 0, 5);
    cyc(ACT, 0, 9);
    chk("R2 open on open bank", int'(bad), 1);
    cyc(NOP);
    chk("R8 row unchanged", row_of(0), 5);
    chk("R8 state unchanged", st_of(0), 1);
    repeat (TRAS) cyc(NOP);
    cyc(PRE, 0);
    cyc(ACT, 0, 7);
    chk("R2 open on closing bank", int'(bad), 1);
    chk("R8 closing unchanged", st_of(0), 2);
    repeat (TRP) cyc(NOP);

    // R5: auto-close
    cyc(ACT, 1, 3);
    repeat (TRCD - 1) cyc(NOP);
    cyc(RD, 1, 0, 1);
    chk("R5 read with auto-close legal", int'(bad), 0);
    for (int k = 1; k <= BLEN + TRP; k++) begin
      if (k == 1) begin
        cyc(RD, 1);
        chk("R5 command during auto-close", int'(bad), 1);
      end else cyc(NOP);
      chk("R5 auto-close phase", st_of(1), (k <= BLEN) ? 3 : (k < BLEN + TRP) ? 2 : 0);
    end

    // R6: close-all
    cyc(ACT, 0, 1);
    cyc(ACT, 1, 2);
    cyc(PREA);
    chk("R6 close-all early", int'(bad), 1);
    repeat (3) cyc(NOP);
    cyc(PREA);
    chk("R6 close-all at tRAS", int'(bad), 0);
    cyc(NOP);
    chk("R6 bank0 closing", st_of(0), 2);
    chk("R6 bank1 closing", st_of(1), 2);
    chk("R6 idle bank stays", st_of(2), 0);
    repeat (TRP - 1) cyc(NOP);
    chk("R6 bank0 closed", st_of(0), 0);
    chk("R6 bank1 closed", st_of(1), 0);

    // R7: mode load and refresh gating
    cyc(ACT, 2, 4);
    cyc(MRS);
    chk("R7 mode load with open bank", int'(bad), 1);
    cyc(REF);
    chk("R7 refresh with open bank", int'(bad), 1);
    close_bank(2);
    cyc(MRS);
    chk("R7 mode load all closed", int'(bad), 0);
    cyc(ACT, 3, 6);
    chk("R7 command inside mode wait", int'(bad), 1);
    cyc(ACT, 3, 6);
    chk("R7 command after mode wait", int'(bad), 0);
    cyc(NOP);
    chk("R7 open after wait", st_of(3), 1);
    close_bank(3);

    // R10: freeze during activity
    cyc(ACT, 0, 8);
    cyc(NOP);
    for (int k = 0; k < 5; k++) begin
      cyc(RD, 0, 0, 0, 0);
      chk("R10 ignored while cke low", int'(bad), 0);
      chk("R10 no power-down while open", int'(pwr_down), 0);
      chk("R10 state held", st_of(0), 1);
    end
    cyc(RD, 0);
    chk("R10 timer frozen", int'(bad), 1);
    cyc(RD, 0);
    chk("R10 timer resumes", int'(bad), 0);
    close_bank(0);

    // R10: power-down when quiet
    cyc(ACT, 1, 2, 0, 0);
    chk("R10 sleep command ignored", int'(bad), 0);
    cyc(NOP, 0, 0, 0, 0);
    chk("R10 power-down entered", int'(pwr_down), 1);
    chk("R10 ignored open", st_of(1), 0);
    cyc(NOP);
    chk("R10 power-down holds one cycle", int'(pwr_down), 1);
    cyc(NOP);
    chk("R10 power-down exit", int'(pwr_down), 0);

    // R9: refresh window accounting
    do cyc(NOP); while (ncyc % WIN != WIN - 1);
    cyc(REF);
    chk("R9 due at window start", int'(refresh_due), 1);
    for (int k = 1; k < NEED; k++) begin
      cyc(REF);
      chk("R9 refresh legal", int'(bad), 0);
      chk("R9 still due", int'(refresh_due), 1);
    end
    cyc(NOP);
    chk("R9 satisfied", int'(refresh_due), 0);
    while (ncyc % WIN != WIN - 1) cyc(NOP);
    chk("R9 satisfied to window end", int'(refresh_due), 0);
    cyc(NOP);
    chk("R9 due in new window", int'(refresh_due), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule